// File: doc/BRIEF.md
# Performance Counter Overflow Controller

This block is a small monitoring unit with four 48-bit event counters. A counter advances by one on each cycle in which its event input is high, but only when two conditions hold: its own enable bit in a control register is set, and the unit-wide enable input is high. When a counter steps from all-ones to zero, a sticky overflow flag is raised for that counter. The flag stays set until software writes a one to the matching bit of a separate clear register.

A read-only summary word collects overflow indications at fixed, sparse bit positions. It holds the unit's own overflow flags together with overflow inputs from neighbouring units: a router-side unit, a memory/home unit, and two pairs of cache slices. Software can therefore find the source of an overflow with one read.

Access is through a simple register port. A write takes one cycle. A read is combinational on the read address.

Top module: `pmon_ovf_unit`

## Requirements
- R1: After reset, all counters, the control field, the status field and the summary word read as zero.
- R2: Counter n (read and write address n, for n = 0..3) increments by one at a clock edge only when `unit_en`, control bit n and `evt_inc[n]` are all 1 in that cycle. Otherwise it holds its value.
- R3: Counters are 48 bits wide. The increment that takes a counter from all-ones to zero sets status bit n at the same edge.
- R4: A write to address n loads `wr_data[47:0]` into counter n. The write overrides an increment in the same cycle and raises no overflow.
- R5: Status bits (address 5, bits 3:0) are sticky. Writing address 6 clears each status bit whose `wr_data` bit is 1 and leaves bits written with 0 unchanged.
- R6: When a clear and a new overflow hit the same status bit in the same cycle, the bit ends up set.
- R7: The control enable field lives in bits 3:0 of address 4 and reads back as written. The clear register at address 6 reads as zero.
- R8: The summary word at address 7 is registered, one cycle behind its inputs. Bit 19 is `ovf_router`, bit 16 is `ovf_mem`, bit 2 is the OR of `ovf_cache_left[1:0]`, and bit 0 is the OR of `ovf_cache_right[1:0]`.
- R9: Summary bit 18 is the OR of the four status bits, one cycle behind the status register.
- R10: All other summary bits, all counter read bits 63:48 and control/status bits 63:4 read as zero. Writes to addresses 5 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| unit_en | input | 1 | Unit-wide counting enable |
| evt_inc | input | 4 | Per-counter event pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 48 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 64 | Read data (combinational) |
| ovf_router | input | 1 | Overflow from router-side unit |
| ovf_mem | input | 1 | Overflow from memory/home unit |
| ovf_cache_left | input | 2 | Overflows from left cache slices |
| ovf_cache_right | input | 2 | Overflows from right cache slices |

## Verification
A write, an increment or an overflow appears on `rd_data` at the first edge after the stimulus. The neighbouring-unit overflow bits of the summary also appear after one edge. Summary bit 18 appears after two edges, because it follows the status register. The bench drives its inputs between a falling edge and the next rising edge. It keeps a reference model that advances once per rising edge. At each following falling edge it reads all eight addresses and compares them with that model, so every result is checked in the cycle it is due.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
    localparam int NUM_CTR = 4;
    localparam int CTR_W   = 48;
    localparam int RD_W    = 64;
    localparam int ADDR_W  = 3;

    localparam logic [ADDR_W-1:0] ADR_CTL  = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_STAT = 3'd5;
    localparam logic [ADDR_W-1:0] ADR_CLR  = 3'd6;
    localparam logic [ADDR_W-1:0] ADR_SUM  = 3'd7;

    localparam int SUM_RTR = 19;
    localparam int SUM_LOC = 18;
    localparam int SUM_MEM = 16;
    localparam int SUM_CL  = 2;
    localparam int SUM_CR  = 0;
endpackage

// File: rtl/pmon_counter.sv
module pmon_counter #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         count_en,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] value,
    output logic         wrap
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } ctr_state_t;

    ctr_state_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        wrap = 1'b0;
        if (load) begin
            s_d.cnt = load_val;
        end else if (count_en) begin
            s_d.cnt = s_q.cnt + W'(1);
            wrap    = &s_q.cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign value = s_q.cnt;

    a_r4_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> value == $past(load_val));
    a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !count_en) |=> $stable(value));
    a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> value == '0);
endmodule

// File: rtl/pmon_status.sv
module pmon_status #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] ov
);
    typedef struct packed {
        logic [N-1:0] ov;
    } stat_state_t;

    stat_state_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.ov = (s_q.ov & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ov = s_q.ov;

    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((ov & $past(set_vec)) == $past(set_vec)));
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((ov & $past(ov & ~clr_vec)) == $past(ov & ~clr_vec)));
    a_r5_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_vec & ~set_vec) != '0) |=> ((ov & $past(clr_vec & ~set_vec)) == '0));
endmodule

// File: rtl/pmon_summary.sv
module pmon_summary
    import pmon_pkg::*;
#(
    parameter int N = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ovf_router,
    input  logic            ovf_mem,
    input  logic [1:0]      ovf_left,
    input  logic [1:0]      ovf_right,
    input  logic [N-1:0]    local_ov,
    output logic [RD_W-1:0] sum_word
);
    typedef struct packed {
        logic rtr;
        logic loc;
        logic mem;
        logic cl;
        logic cr;
    } sum_state_t;

    sum_state_t s_d, s_q;

    always_comb begin
        s_d.rtr = ovf_router;
        s_d.loc = |local_ov;
        s_d.mem = ovf_mem;
        s_d.cl  = |ovf_left;
        s_d.cr  = |ovf_right;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        sum_word          = '0;
        sum_word[SUM_RTR] = s_q.rtr;
        sum_word[SUM_LOC] = s_q.loc;
        sum_word[SUM_MEM] = s_q.mem;
        sum_word[SUM_CL]  = s_q.cl;
        sum_word[SUM_CR]  = s_q.cr;
    end

    a_r8_router_flag: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> sum_word[SUM_RTR] == $past(ovf_router));
    a_r8_left_pair: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> sum_word[SUM_CL] == $past(ovf_left != 2'b00));
    a_r9_local_flag: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> sum_word[SUM_LOC] == $past(local_ov != '0));
endmodule

// File: rtl/pmon_ovf_unit.sv
module pmon_ovf_unit
    import pmon_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              unit_en,
    input  logic [NUM_CTR-1:0] evt_inc,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CTR_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [RD_W-1:0]   rd_data,
    input  logic              ovf_router,
    input  logic              ovf_mem,
    input  logic [1:0]        ovf_cache_left,
    input  logic [1:0]        ovf_cache_right
);
    typedef struct packed {
        logic [NUM_CTR-1:0] en;
    } ctl_state_t;

    ctl_state_t c_d, c_q;

    logic [NUM_CTR-1:0][CTR_W-1:0] cnt_val;
    logic [NUM_CTR-1:0]            wrap_vec;
    logic [NUM_CTR-1:0]            clr_vec;
    logic [NUM_CTR-1:0]            stat_ov;
    logic [RD_W-1:0]               sum_word;

    always_comb begin
        c_d = c_q;
        if (wr_en && wr_addr == ADR_CTL) c_d.en = wr_data[NUM_CTR-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign clr_vec = (wr_en && wr_addr == ADR_CLR) ? wr_data[NUM_CTR-1:0] : '0;

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        pmon_counter #(.W(CTR_W)) u_ctr (
            .clk      (clk),
            .rst_n    (rst_n),
            .count_en (unit_en & c_q.en[i] & evt_inc[i]),
            .load     (wr_en && wr_addr == ADDR_W'(i)),
            .load_val (wr_data),
            .value    (cnt_val[i]),
            .wrap     (wrap_vec[i])
        );
    end

    pmon_status #(.N(NUM_CTR)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (wrap_vec),
        .clr_vec (clr_vec),
        .ov      (stat_ov)
    );

    pmon_summary #(.N(NUM_CTR)) u_summary (
        .clk        (clk),
        .rst_n      (rst_n),
        .ovf_router (ovf_router),
        .ovf_mem    (ovf_mem),
        .ovf_left   (ovf_cache_left),
        .ovf_right  (ovf_cache_right),
        .local_ov   (stat_ov),
        .sum_word   (sum_word)
    );

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CTR; i++) begin
            if (rd_addr == ADDR_W'(i)) rd_data = RD_W'(cnt_val[i]);
        end
        case (rd_addr)
            ADR_CTL:  rd_data = RD_W'(c_q.en);
            ADR_STAT: rd_data = RD_W'(stat_ov);
            ADR_SUM:  rd_data = sum_word;
            default:  ;
        endcase
    end

    a_r7_ctl_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADR_CTL) |=> c_q.en == $past(wr_data[NUM_CTR-1:0]));
    a_r2_unit_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!unit_en && !(wr_en && wr_addr < ADDR_W'(NUM_CTR))) |=> $stable(cnt_val));
endmodule

// File: tb/pmon_ovf_unit_tb_top.sv
module pmon_ovf_unit_tb_top;
    localparam int PERIOD = 20;
    localparam logic [47:0] MAXV = 48'hFFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        unit_en = 1'b0;
    logic [3:0]  evt_inc = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [47:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [63:0] rd_data;
    logic        ovf_router = 1'b0;
    logic        ovf_mem = 1'b0;
    logic [1:0]  ovf_cache_left = '0;
    logic [1:0]  ovf_cache_right = '0;

    int checks = 0;
    int errors = 0;
    string phase = "R1";

    logic [47:0] m_cnt [4];
    logic [3:0]  m_ctl;
    logic [3:0]  m_st;
    logic [63:0] m_sum;

    always #(PERIOD/2) clk = ~clk;

    pmon_ovf_unit dut_i (
        .clk(clk), .rst_n(rst_n), .unit_en(unit_en), .evt_inc(evt_inc),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .ovf_router(ovf_router), .ovf_mem(ovf_mem),
        .ovf_cache_left(ovf_cache_left), .ovf_cache_right(ovf_cache_right)
    );

    function automatic logic [63:0] exp_read(int a);
        if (a < 4)  return {16'h0, m_cnt[a]};
        if (a == 4) return {60'h0, m_ctl};
        if (a == 5) return {60'h0, m_st};
        if (a == 6) return 64'h0;
        return m_sum;
    endfunction

    function automatic string tag_of(int a);
        if (a < 4)  return "R2";
        if (a == 4) return "R7";
        if (a == 5) return "R5";
        if (a == 6) return "R7";
        return "R8";
    endfunction

    task automatic check_all();
        for (int a = 0; a < 8; a++) begin
            rd_addr = 3'(a);
            #1;
            checks++;
            if (rd_data !== exp_read(a)) begin
                errors++;
                $display("FAIL %s/%s addr %0d got %h exp %h", phase, tag_of(a), a, rd_data, exp_read(a));
            end
        end
    endtask

    task automatic step();
        logic [47:0] n_cnt [4];
        logic [3:0]  ovf = '0;
        logic [3:0]  clr;
        logic [63:0] n_sum = '0;
        for (int n = 0; n < 4; n++) begin
            n_cnt[n] = m_cnt[n];
            if (wr_en && wr_addr == 3'(n)) n_cnt[n] = wr_data;
            else if (unit_en && m_ctl[n] && evt_inc[n]) begin
                ovf[n] = (m_cnt[n] == MAXV);
                n_cnt[n] = m_cnt[n] + 48'd1;
            end
        end
        clr = (wr_en && wr_addr == 3'd6) ? wr_data[3:0] : 4'h0;
        n_sum[19] = ovf_router;
        n_sum[18] = |m_st;
        n_sum[16] = ovf_mem;
        n_sum[2]  = |ovf_cache_left;
        n_sum[0]  = |ovf_cache_right;
        @(posedge clk);
        @(negedge clk);
        for (int n = 0; n < 4; n++) m_cnt[n] = n_cnt[n];
        if (wr_en && wr_addr == 3'd4) m_ctl = wr_data[3:0];
        m_st  = (m_st & ~clr) | ovf;
        m_sum = n_sum;
        check_all();
    endtask

    task automatic wr(input logic [2:0] a, input logic [47:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    initial begin
        #(PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int n = 0; n < 4; n++) m_cnt[n] = '0;
        m_ctl = '0; m_st = '0; m_sum = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        phase = "R1";
        check_all();

        // R2: counting needs unit_en and the per-counter enable
        phase = "R2";
        evt_inc = 4'hF; unit_en = 1'b1;
        step();
        wr(3'd4, 48'h5);
        step();
        unit_en = 1'b0;
        step();
        unit_en = 1'b1;

        // R3: wrap from all-ones sets status; R9 follows one edge later
        phase = "R3";
        wr(3'd0, MAXV - 48'd1);
        step();
        step();
        phase = "R9";
        evt_inc = 4'h0;
        step();

        // R4: a write overrides an increment
        phase = "R4";
        evt_inc = 4'h4;
        wr(3'd2, MAXV);
        wr(3'd2, 48'h1234);

        // R6: clear and new overflow on the same bit
        phase = "R6";
        evt_inc = 4'h0;
        wr(3'd0, MAXV);
        evt_inc = 4'h1;
        wr(3'd6, 48'h1);
        evt_inc = 4'h0;

        // R5: clear with a zero bit leaves the flag set, with a one clears it
        phase = "R5";
        wr(3'd6, 48'h2);
        wr(3'd6, 48'h1);

        // R10: writes to status and summary are ignored
        phase = "R10";
        wr(3'd0, MAXV);
        evt_inc = 4'h1;
        step();
        evt_inc = 4'h0;
        wr(3'd5, MAXV);
        wr(3'd7, MAXV);

        // R8: external overflow inputs
        phase = "R8";
        ovf_router = 1'b1; ovf_cache_left = 2'b10; step();
        ovf_router = 1'b0; ovf_mem = 1'b1; ovf_cache_right = 2'b01; ovf_cache_left = 2'b00; step();
        ovf_mem = 1'b0; ovf_cache_right = 2'b00; step();

        // random mix, named by address (R2, R5, R7, R8)
        phase = "RND";
        for (int c = 0; c < 3000; c++) begin
            unit_en = ($urandom % 10) < 8;
            evt_inc = 4'($urandom);
            ovf_router = 1'($urandom);
            ovf_mem = 1'($urandom);
            ovf_cache_left = 2'($urandom);
            ovf_cache_right = 2'($urandom);
            wr_en = ($urandom % 10) < 3;
            wr_addr = 3'($urandom);
            if ($urandom % 2) wr_data = MAXV - 48'($urandom % 4);
            else wr_data = {16'($urandom), 32'($urandom)};
            step();
            wr_en = 1'b0;
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule